// File: doc/BRIEF.md
# Quasi-Resonant Valley Switching Timer

This block decides when the primary switch of a quasi-resonant flyback stage turns on and off. It runs from one reference clock and sees three comparator results that are already digital: whether the sync winding voltage is above the valley threshold, whether it is still above the high level, and whether the sensed switch current has crossed its limit. It drives a single gate-enable output.

Every switching cycle has an on phase and an off phase. The on phase ends on a current trip, which is ignored during a short leading-edge interval, or at a hard on-time ceiling. The off phase starts with a fixed blanking interval in which no turn-on may happen. When blanking ends, one of two things follows. If the sync voltage is still above the high level, the switch turns on after a short fixed hold. Otherwise the block watches a bounded window for a valley and turns on at that valley. If no valley comes before the window closes, the switch is forced on. When on-times are short, the block alternates between turning on at the first valley for two cycles and at the second valley for two cycles. This spreads the switching frequency. A disable input stops switching at once and restarts the off-phase timing when it is released. All durations are parameters counted in clock cycles.

Top module: `qr_valley_timer`

## Requirements
- R1: While `rst_i` is high, `gate_o` is low. The clock edge that samples `rst_i` low starts an off phase with cycle index 0, and that off phase follows the same rules as any other.
- R2: A falling edge of `sync_above_i` during the blanking interval does not cause a turn-on, and it does not count as a valley.
- R3: When `sync_high_i` is low at the last blanking cycle and first-valley turn-on applies, `gate_o` rises one cycle after the first falling edge of `sync_above_i` seen in the detection window. The gate is then low for exactly (cycle index of that edge + 1) cycles.
- R4: If no qualifying valley occurs in the detection window, `gate_o` rises after exactly BLANK_CYC + WIN_CYC low cycles.
- R5: When `sync_high_i` is high at the last blanking cycle, `gate_o` rises after exactly BLANK_CYC + HOLD_CYC low cycles, whatever `sync_above_i` does.
- R6: When the previous on-time was short, turn-ons use the first valley or the second valley according to a count of turn-ons modulo 2*GROUP_LEN. The count is taken before each turn-on. Counts 0 to GROUP_LEN-1 select the first valley, and the remaining counts select the second valley.
- R7: Second-valley turn-on applies only when the preceding on-time was strictly shorter than AVS_ON_CYC cycles. An on-time of AVS_ON_CYC-1 cycles engages it, and one of AVS_ON_CYC cycles does not.
- R8: The turn-on count advances on every turn-on, including turn-ons made while second-valley selection is off.
- R9: `trip_i` is ignored during the first LEB_CYC cycles of an on phase. A trip held high from the start gives an on-time of LEB_CYC + 1 cycles.
- R10: After the blanking-of-trip interval, a trip seen in on-cycle index j ends the on phase, so the on-time is j + 1 cycles.
- R11: The on-time never exceeds MAX_ON_CYC cycles. Without a trip it is exactly MAX_ON_CYC cycles.
- R12: `gate_o` is low in the same cycle that `dis_i` goes high, and stays low while `dis_i` is high. The first cycle with `dis_i` low counts as off-cycle index 0 of a new off phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dis_i | input | 1 | Global disable; forces the gate low and restarts off timing |
| sync_above_i | input | 1 | High while the sync voltage is above the valley threshold; a falling edge marks a valley |
| sync_high_i | input | 1 | High while the sync voltage is above the high level |
| trip_i | input | 1 | Current-limit comparator result |
| gate_o | output | 1 | Gate enable for the power switch |

## Verification
Every result shows on `gate_o` one clock after the event that decides it. A valley edge, a forced window end or a hold expiry registers the turn-on at the next edge. A trip or the on-time ceiling registers the turn-off in the same way. Disable is the exception: it acts on the gate in the same cycle. The bench drives inputs and samples the gate on falling clock edges. It indexes each off phase from its first low sample and each on phase from its first high sample, and drives every stimulus at a known index. Each check compares the measured count of low or high samples with the count the requirement predicts, for example BLANK_CYC + 3 for a valley at window index 2. The disable check is taken one time step after `dis_i` rises, before any clock edge.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

    typedef enum logic [1:0] {
        PH_BLANK = 2'd0,
        PH_HOLD  = 2'd1,
        PH_WIN   = 2'd2,
        PH_WAIT  = 2'd3
    } off_phase_e;

    typedef struct packed {
        logic done;
        logic short_on;
    } on_report_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/qrv_on_timer.sv
module qrv_on_timer
    import qrv_pkg::*;
#(
    parameter int unsigned LEB_CYC    = 4,
    parameter int unsigned MAX_ON_CYC = 20,
    parameter int unsigned AVS_ON_CYC = 8
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       dis_i,
    input  logic       fire_i,
    input  logic       trip_i,
    output logic       on_o,
    output on_report_t rpt_o
);
    localparam int unsigned W = $clog2(MAX_ON_CYC + 1);
    localparam logic [W-1:0] LEB_W  = W'(LEB_CYC);
    localparam logic [W-1:0] LAST_W = W'(MAX_ON_CYC - 1);
    localparam logic [W:0]   AVS_W  = (W+1)'(AVS_ON_CYC);

    logic         on_q;
    logic [W-1:0] cnt_q;
    logic         end_c;
    logic [W:0]   len_c;

    assign end_c = on_q & (dis_i | (trip_i & (cnt_q >= LEB_W)) | (cnt_q == LAST_W));
    assign len_c = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            on_q  <= 1'b0;
            cnt_q <= '0;
        end else if (on_q) begin
            if (end_c) begin
                on_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (fire_i && !dis_i) begin
            on_q  <= 1'b1;
            cnt_q <= '0;
        end
    end

    assign on_o           = on_q;
    assign rpt_o.done     = end_c;
    assign rpt_o.short_on = len_c < AVS_W;

endmodule

// File: rtl/qrv_off_sched.sv
module qrv_off_sched
    import qrv_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 30,
    parameter int unsigned WIN_CYC   = 12,
    parameter int unsigned HOLD_CYC  = 5
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic dis_i,
    input  logic done_i,
    input  logic sync_above_i,
    input  logic sync_high_i,
    input  logic second_valley_i,
    output logic fire_o
);
    localparam int unsigned LONGEST = max3(BLANK_CYC, WIN_CYC, HOLD_CYC);
    localparam int unsigned W = $clog2(LONGEST + 1);
    localparam logic [W-1:0] BLANK_END = W'(BLANK_CYC - 1);
    localparam logic [W-1:0] WIN_END   = W'(WIN_CYC - 1);
    localparam logic [W-1:0] HOLD_END  = W'(HOLD_CYC - 1);

    off_phase_e   phase_q;
    logic [W-1:0] cnt_q;
    logic         seen_q;
    logic         sync_prev_q;
    logic         valley_c;
    logic         hit_c;

    assign valley_c = sync_prev_q & ~sync_above_i;
    assign hit_c    = valley_c & (~second_valley_i | seen_q);

    always_comb begin
        fire_o = 1'b0;
        if (!dis_i) begin
            case (phase_q)
                PH_HOLD: fire_o = (cnt_q == HOLD_END);
                PH_WIN:  fire_o = hit_c | (cnt_q == WIN_END);
                default: fire_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_prev_q <= 1'b0;
        end else begin
            sync_prev_q <= sync_above_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || dis_i) begin
            phase_q <= PH_BLANK;
            cnt_q   <= '0;
            seen_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_WAIT: begin
                    if (done_i) begin
                        phase_q <= PH_BLANK;
                        cnt_q   <= '0;
                    end
                end
                PH_BLANK: begin
                    if (cnt_q == BLANK_END) begin
                        cnt_q   <= '0;
                        seen_q  <= 1'b0;
                        phase_q <= sync_high_i ? PH_HOLD : PH_WIN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (fire_o) begin
                        phase_q <= PH_WAIT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (fire_o) begin
                        phase_q <= PH_WAIT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        if (valley_c) begin
                            seen_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/qrv_avs_sel.sv
module qrv_avs_sel #(
    parameter int unsigned GROUP_LEN = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic turn_on_i,
    input  logic done_i,
    input  logic short_on_i,
    output logic second_valley_o
);
    localparam int unsigned PERIOD = 2 * GROUP_LEN;
    localparam int unsigned W      = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST  = W'(PERIOD - 1);
    localparam logic [W-1:0] SPLIT = W'(GROUP_LEN);

    logic [W-1:0] pulse_cnt_q;
    logic         engaged_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pulse_cnt_q <= '0;
            engaged_q   <= 1'b0;
        end else begin
            if (turn_on_i) begin
                pulse_cnt_q <= (pulse_cnt_q == LAST) ? '0 : pulse_cnt_q + 1'b1;
            end
            if (done_i) begin
                engaged_q <= short_on_i;
            end
        end
    end

    assign second_valley_o = engaged_q & (pulse_cnt_q >= SPLIT);

endmodule

// File: rtl/qr_valley_timer.sv
module qr_valley_timer
    import qrv_pkg::*;
#(
    parameter int unsigned BLANK_CYC  = 30,
    parameter int unsigned WIN_CYC    = 12,
    parameter int unsigned HOLD_CYC   = 5,
    parameter int unsigned LEB_CYC    = 4,
    parameter int unsigned MAX_ON_CYC = 20,
    parameter int unsigned AVS_ON_CYC = 8,
    parameter int unsigned GROUP_LEN  = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic dis_i,
    input  logic sync_above_i,
    input  logic sync_high_i,
    input  logic trip_i,
    output logic gate_o
);
    logic       fire;
    logic       on_state;
    logic       second_valley;
    on_report_t rpt;

    qrv_off_sched #(
        .BLANK_CYC(BLANK_CYC),
        .WIN_CYC  (WIN_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_off (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .dis_i          (dis_i),
        .done_i         (rpt.done),
        .sync_above_i   (sync_above_i),
        .sync_high_i    (sync_high_i),
        .second_valley_i(second_valley),
        .fire_o         (fire)
    );

    qrv_on_timer #(
        .LEB_CYC   (LEB_CYC),
        .MAX_ON_CYC(MAX_ON_CYC),
        .AVS_ON_CYC(AVS_ON_CYC)
    ) u_on (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .dis_i (dis_i),
        .fire_i(fire),
        .trip_i(trip_i),
        .on_o  (on_state),
        .rpt_o (rpt)
    );

    qrv_avs_sel #(
        .GROUP_LEN(GROUP_LEN)
    ) u_avs (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .turn_on_i      (fire),
        .done_i         (rpt.done),
        .short_on_i     (rpt.short_on),
        .second_valley_o(second_valley)
    );

    assign gate_o = on_state & ~dis_i;

endmodule

// File: rtl/qrv_checker.sv
module qrv_checker #(
    parameter int unsigned BLANK_CYC  = 30,
    parameter int unsigned WIN_CYC    = 12,
    parameter int unsigned HOLD_CYC   = 5,
    parameter int unsigned LEB_CYC    = 4,
    parameter int unsigned MAX_ON_CYC = 20
) (
    input logic clk_i,
    input logic rst_i,
    input logic dis_i,
    input logic gate_o
);
    localparam int unsigned WAIT_MAX = (WIN_CYC > HOLD_CYC) ? WIN_CYC : HOLD_CYC;

    logic [15:0] low_cnt;
    logic [15:0] high_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i || dis_i || gate_o) begin
            low_cnt <= '0;
        end else if (low_cnt != 16'hFFFF) begin
            low_cnt <= low_cnt + 16'd1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !gate_o) begin
            high_cnt <= '0;
        end else if (high_cnt != 16'hFFFF) begin
            high_cnt <= high_cnt + 16'd1;
        end
    end

    // R2: a turn-on is preceded by at least the blanking interval
    p_blank_before_on_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(gate_o) |-> (low_cnt >= 16'(BLANK_CYC)));

    // R4: the off phase is bounded by blanking plus the longer of window and hold
    p_off_bounded_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        low_cnt <= 16'(BLANK_CYC + WAIT_MAX));

    // R11: on-time ceiling
    p_on_ceiling_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        high_cnt <= 16'(MAX_ON_CYC));

    // R9: an on phase not cut by disable lasts longer than the trip blanking
    p_trip_blanked_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(gate_o) && !dis_i && !$past(dis_i)) |-> (high_cnt >= 16'(LEB_CYC + 1)));

    // R12: disable keeps the gate low in the following cycle
    p_dis_holds_low_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        dis_i |=> !gate_o);

endmodule

bind qr_valley_timer qrv_checker #(
    .BLANK_CYC (BLANK_CYC),
    .WIN_CYC   (WIN_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .LEB_CYC   (LEB_CYC),
    .MAX_ON_CYC(MAX_ON_CYC)
) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .dis_i (dis_i),
    .gate_o(gate_o)
);

// File: tb/qr_valley_timer_tb.sv
module qr_valley_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BLANK  = 30;
    localparam int WIN    = 12;
    localparam int HOLD   = 5;
    localparam int LEB    = 4;
    localparam int MAX_ON = 20;
    localparam int AVS_ON = 8;

    localparam int M_VALLEY = 0;
    localparam int M_NOVAL  = 1;
    localparam int M_HIGH   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dis = 1'b0;
    logic s_above = 1'b1;
    logic s_high = 1'b1;
    logic trip = 1'b0;
    logic gate;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qr_valley_timer #(
        .BLANK_CYC (BLANK),
        .WIN_CYC   (WIN),
        .HOLD_CYC  (HOLD),
        .LEB_CYC   (LEB),
        .MAX_ON_CYC(MAX_ON),
        .AVS_ON_CYC(AVS_ON),
        .GROUP_LEN (2)
    ) u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .dis_i       (dis),
        .sync_above_i(s_above),
        .sync_high_i (s_high),
        .trip_i      (trip),
        .gate_o      (gate)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ends on the negedge where rst is released: off-cycle index 0
    task automatic do_reset();
        rst = 1'b1; dis = 1'b0; trip = 1'b0; s_above = 1'b1; s_high = 1'b1;
        repeat (3) @(negedge clk);
        check(int'(gate), 0, "R1 gate low in reset");
        rst = 1'b0;
    endtask

    // called at off-cycle index 0; returns at the first high sample
    task automatic run_off(input int mode, input int exp, input string tag);
        int k = 0;
        while (gate == 1'b0 && k < 200) begin
            if (k == 0) begin s_above = 1'b1; s_high = 1'b1; end
            if (mode != M_HIGH) begin
                if (k == 10) s_high = 1'b0;
                if (k == 5) s_above = 1'b0;
                if (k == 8) s_above = 1'b1;
            end
            if (mode == M_VALLEY) begin
                if (k == BLANK + 2) s_above = 1'b0;
                if (k == BLANK + 5) s_above = 1'b1;
                if (k == BLANK + 8) s_above = 1'b0;
                if (k == BLANK + 11) s_above = 1'b1;
            end
            k++;
            @(negedge clk);
        end
        check(k, exp, tag);
    endtask

    // called at on-cycle index 0; trip high for tf <= j <= tt
    task automatic run_on(input int tf, input int tt, input int exp, input string tag);
        int j = 0;
        while (gate == 1'b1 && j < 200) begin
            trip = (j >= tf) && (j <= tt);
            j++;
            @(negedge clk);
        end
        trip = 1'b0;
        check(j, exp, tag);
    endtask

    task automatic t_basic();
        do_reset();
        run_off(M_HIGH, BLANK + HOLD, "R1 R5 hold after reset");
        run_on(0, 999, LEB + 1, "R9 trip held from start");
        run_off(M_NOVAL, BLANK + WIN, "R2 R4 forced turn-on");
        run_on(1, 2, MAX_ON, "R9 R11 early trip ignored");
        run_off(M_VALLEY, BLANK + 3, "R3 first valley");
        run_on(99, 99, MAX_ON, "R11 no trip");
    endtask

    task automatic t_alternate();
        int exp_len [6] = '{BLANK + 3, BLANK + 9, BLANK + 9, BLANK + 3, BLANK + 3, BLANK + 9};
        do_reset();
        run_off(M_HIGH, BLANK + HOLD, "R5 hold");
        for (int n = 0; n < 6; n++) begin
            run_on(0, 999, LEB + 1, "R9 short pulse");
            run_off(M_VALLEY, exp_len[n], "R6 valley pattern");
        end
        run_on(0, 999, LEB + 1, "R9 short pulse");
    endtask

    task automatic t_threshold();
        do_reset();
        run_off(M_HIGH, BLANK + HOLD, "R5 hold");
        run_on(99, 99, MAX_ON, "R11 long");
        run_off(M_VALLEY, BLANK + 3, "R7 long on-time, first valley");
        run_on(AVS_ON - 2, 999, AVS_ON - 1, "R10 trip ends pulse");
        run_off(M_VALLEY, BLANK + 9, "R7 on-time below limit, second valley");
        run_on(AVS_ON - 1, 999, AVS_ON, "R10 trip ends pulse");
        run_off(M_VALLEY, BLANK + 3, "R7 on-time at limit, first valley");
        run_on(99, 99, MAX_ON, "R11 long");
    endtask

    task automatic t_counter();
        do_reset();
        run_off(M_HIGH, BLANK + HOLD, "R5 hold");
        run_on(99, 99, MAX_ON, "R11 long");
        run_off(M_VALLEY, BLANK + 3, "R8 inactive count 1");
        run_on(99, 99, MAX_ON, "R11 long");
        run_off(M_VALLEY, BLANK + 3, "R8 inactive count 2");
        run_on(0, 999, LEB + 1, "R9 short");
        run_off(M_VALLEY, BLANK + 9, "R8 count kept running");
        run_on(0, 999, LEB + 1, "R9 short");
        run_off(M_VALLEY, BLANK + 3, "R8 count wrapped");
        run_on(99, 99, MAX_ON, "R11 long");
    endtask

    task automatic t_disable();
        do_reset();
        run_off(M_HIGH, BLANK + HOLD, "R5 hold");
        repeat (3) @(negedge clk);
        dis = 1'b1;
        #1;
        check(int'(gate), 0, "R12 gate drops with disable");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(int'(gate), 0, "R12 gate low while disabled");
        end
        dis = 1'b0;
        run_off(M_HIGH, BLANK + HOLD, "R12 restart after disable");
        run_on(99, 99, MAX_ON, "R11 long");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_basic();
        t_alternate();
        t_threshold();
        t_counter();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule